// File: doc/BRIEF.md
# Scanline Timing Generator

This block derives the horizontal and vertical timing of a raster display from one system clock. A horizontal position counter defines the length of every line and wraps once per line. On lines that fall in the picture region it produces a horizontal sync pulse between two compare points on that counter.

Each horizontal wrap advances a line counter. The line counter drives a sequencer with four vertical phases, taken in this order: front porch, vertical sync, picture, back porch. The sequencer changes phase when the line counter reaches a threshold set for the current phase. When the back porch reaches the frame length, the line counter returns to zero and the sequencer goes back to the front porch.

The outputs are horizontal sync, vertical sync, a one-cycle strobe at the end of each line, a flag for picture lines and the current line number. Pixel data is produced downstream, timed from these outputs.

Top module: `scanline_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters this state: horizontal position 0, line number 0, front-porch phase. In the cycle after that edge, `hsync`, `vsync`, `line_start` and `visible` are 0 and `line_idx` is 0.
- R2: The horizontal position runs from 0 to LINE_CYCLES-1 (default 627) and then wraps to 0. `line_start` is high for exactly one cycle per line, the cycle at position LINE_CYCLES-1. The first strobe after reset comes LINE_CYCLES-1 cycles after reset is released.
- R3: `line_idx` increases by one at each horizontal wrap, except where R7 applies.
- R4: `vsync` is high on lines VSYNC_LINE to VIS_LINE-1 (default 1 to 3) and low on all other lines.
- R5: `visible` is high on lines VIS_LINE to BP_LINE-1 (default 4 to 515) and low on all other lines.
- R6: On a picture line, `hsync` is high for horizontal positions HS_ON to HS_OFF-1 (default 16 to 31), which is HS_OFF-HS_ON cycles per line. It is low at every other position and on every line outside the picture region.
- R7: At the wrap that ends line FRAME_LINES-1 (default 530), `line_idx` returns to 0 and the front porch starts again. A frame is therefore FRAME_LINES lines long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | output | 1 | Horizontal sync pulse, active high, picture lines only |
| vsync | output | 1 | Vertical sync, active high |
| line_start | output | 1 | One-cycle strobe in the last cycle of each line |
| visible | output | 1 | High on picture lines |
| line_idx | output | $clog2(FRAME_LINES+1) | Current line number within the frame |

## Verification
The assertions take only one thing for granted about the inputs: reset is held for at least one clock edge before any property is evaluated. Apart from reset there are no inputs to constrain. The stimulus sets `rst` high from time zero and releases it away from a clock edge. To keep the run short, the bench shortens the vertical thresholds while keeping the default line length. It also applies a second reset partway through a line to check that the restart is clean.

// File: rtl/scanline_timer.sv
module scanline_timer #(
  parameter int LINE_CYCLES = 628,
  parameter int HS_ON       = 16,
  parameter int HS_OFF      = 32,
  parameter int VSYNC_LINE  = 1,
  parameter int VIS_LINE    = 4,
  parameter int BP_LINE     = 516,
  parameter int FRAME_LINES = 531
) (
  input  logic clk,
  input  logic rst,
  output logic hsync,
  output logic vsync,
  output logic line_start,
  output logic visible,
  output logic [$clog2(FRAME_LINES+1)-1:0] line_idx
);
  localparam int HW = $clog2(LINE_CYCLES);
  localparam int LW = $clog2(FRAME_LINES+1);

  typedef enum logic [1:0] {PH_FP, PH_VS, PH_VIS, PH_BP} phase_t;

  logic [HW-1:0] hcnt;
  logic          hs_en;
  phase_t        ph;
  logic          wrap;
  logic [LW-1:0] nl;

  assign wrap = (hcnt == HW'(LINE_CYCLES-1));
  assign nl   = line_idx + LW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt     <= '0;
      line_idx <= '0;
      ph       <= PH_FP;
      hs_en    <= 1'b0;
    end else begin
      hcnt <= wrap ? '0 : hcnt + HW'(1);
      if (wrap) begin
        line_idx <= nl;
        case (ph)
          PH_FP:  if (nl == LW'(VSYNC_LINE)) ph <= PH_VS;
          PH_VS:  if (nl == LW'(VIS_LINE)) begin
                    ph    <= PH_VIS;
                    hs_en <= 1'b1;
                  end
          PH_VIS: if (nl == LW'(BP_LINE)) begin
                    ph    <= PH_BP;
                    hs_en <= 1'b0;
                  end
          default: if (nl == LW'(FRAME_LINES)) begin
                    ph       <= PH_FP;
                    line_idx <= '0;
                  end
        endcase
      end
    end
  end

  assign line_start = wrap;
  assign vsync      = (ph == PH_VS);
  assign visible    = (ph == PH_VIS);
  assign hsync      = hs_en && (hcnt >= HW'(HS_ON)) && (hcnt < HW'(HS_OFF));

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (hcnt == '0));

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (line_idx == $past(line_idx) + LW'(1)) || (line_idx == '0));

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(line_idx));

  // R4
  vsync_window_chk: assert property (@(posedge clk) disable iff (rst)
    vsync |-> (line_idx >= LW'(VSYNC_LINE)) && (line_idx < LW'(VIS_LINE)));

  // R5
  visible_window_chk: assert property (@(posedge clk) disable iff (rst)
    visible |-> (line_idx >= LW'(VIS_LINE)) && (line_idx < LW'(BP_LINE)));

  // R6
  hsync_gate_chk: assert property (@(posedge clk) disable iff (rst)
    hsync |-> visible);

  // R7
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start && line_idx == LW'(FRAME_LINES-1)) |=> (line_idx == '0) && !vsync && !visible);
endmodule

// File: tb/tb_scanline_timer.sv
module tb_scanline_timer;
  localparam int LC = 628;
  localparam int FR = 25;
  localparam int BP = 20;
  localparam int LW = $clog2(FR+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync, vsync, line_start, visible;
  logic [LW-1:0] line_idx;

  int n_chk = 0;
  int n_bad = 0;
  longint now = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scanline_timer #(.LINE_CYCLES(LC), .HS_ON(16), .HS_OFF(32), .VSYNC_LINE(1),
                   .VIS_LINE(4), .BP_LINE(BP), .FRAME_LINES(FR)) dut (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
    .line_start(line_start), .visible(visible), .line_idx(line_idx));

  // columns: abs line, hpos, idx, line_start, hsync, vsync, visible
  localparam int NV = 20;
  localparam int TBL [0:NV-1][0:6] = '{
    '{0,   0, 0, 0,0,0,0},
    '{0,  16, 0, 0,0,0,0},
    '{0, 627, 0, 1,0,0,0},
    '{1,   0, 1, 0,0,1,0},
    '{1,  20, 1, 0,0,1,0},
    '{3, 627, 3, 1,0,1,0},
    '{4,   0, 4, 0,0,0,1},
    '{4,  15, 4, 0,0,0,1},
    '{4,  16, 4, 0,1,0,1},
    '{4,  31, 4, 0,1,0,1},
    '{4,  32, 4, 0,0,0,1},
    '{10, 20, 10,0,1,0,1},
    '{19, 16, 19,0,1,0,1},
    '{19,627, 19,1,0,0,1},
    '{20, 16, 20,0,0,0,0},
    '{24,627, 24,1,0,0,0},
    '{25,  0, 0, 0,0,0,0},
    '{25, 20, 0, 0,0,0,0},
    '{26,  5, 1, 0,0,1,0},
    '{29, 16, 4, 0,1,0,1}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at t=%0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic goto(input longint pos);
    while (now < pos) begin
      @(negedge clk);
      now++;
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    now = 0;
    // R1 reset state
    chk("R1 hsync", hsync, 0);
    chk("R1 vsync", vsync, 0);
    chk("R1 line_start", line_start, 0);
    chk("R1 visible", visible, 0);
    chk("R1 line_idx", line_idx, 0);

    for (int i = 0; i < NV; i++) begin
      goto(longint'(TBL[i][0]) * LC + TBL[i][1]);
      chk("R3/R7 line_idx", line_idx, TBL[i][2]);
      chk("R2 line_start", line_start, TBL[i][3]);
      chk("R6 hsync", hsync, TBL[i][4]);
      chk("R4 vsync", vsync, TBL[i][5]);
      chk("R5 visible", visible, TBL[i][6]);
    end

    // R6: pulse width over one full picture line
    begin
      int hs_cnt = 0;
      int ls_cnt = 0;
      goto(longint'(FR + 6) * LC);
      for (int k = 0; k < LC; k++) begin
        if (hsync) hs_cnt++;
        if (line_start) ls_cnt++;
        @(negedge clk);
        now++;
      end
      chk("R6 hsync width", hs_cnt, 16);
      chk("R2 strobe count", ls_cnt, 1);
    end

    // R1: reset in the middle of a picture line
    goto(longint'(FR + 8) * LC + 20);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    now = 0;
    chk("R1 hsync after reset", hsync, 0);
    chk("R1 visible after reset", visible, 0);
    chk("R1 line_idx after reset", line_idx, 0);
    goto(626);
    chk("R2 no early strobe", line_start, 0);
    goto(627);
    chk("R2 first strobe", line_start, 1);
    goto(628);
    chk("R3 line advance", line_idx, 1);
    chk("R4 vsync line 1", vsync, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule